// File: doc/BRIEF.md
# Programmable-Format Serial Transmitter

This block turns a parallel character into an asynchronous serial frame on a single output line. A small format register, loaded through its own strobe, selects the character length (5 to 8 bits), whether a parity bit is appended and its sense, and the stop-bit count. Each frame begins with a low start bit and carries the data least significant bit first. Then come the optional parity bit and the high stop bits. The idle line sits high.

The clock input runs at sixteen times the bit rate, so each bit lasts sixteen clock cycles. A character is written into a holding buffer with a load strobe. The buffer passes its content to the frame shifter as soon as the shifter can take it, which frees the buffer for the next character while the current one is still being sent. Two flags report whether the buffer and the shifter are empty. The format is sampled when a character enters the shifter, so a format change never disturbs a frame in flight.

Top module: `async_tx_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns after that edge to `ser_out`=1, `hold_empty`=1, `shift_empty`=1, and any frame in progress is abandoned.
- R2: `load_stb` high at an edge stores `hold_data` and makes `hold_empty` 0 after that edge. If the shifter is idle, the next edge moves the character into the shifter, sets `hold_empty` to 1 and sets `shift_empty` to 0.
- R3: A frame starts with a start bit of 0 lasting 16 cycles, followed by the data bits LSB first, each lasting 16 cycles.
- R4: `len_sel` encodes the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7, 11 gives 8. Holding bits above the selected length are not sent.
- R5: With `par_off`=1 no parity bit is sent, and `par_even` has no effect on the line.
- R6: With `par_off`=0 a parity bit follows the data. With `par_even`=1 the parity bit makes the count of ones in data plus parity even. With `par_even`=0 it makes the count odd.
- R7: With `stop_sel`=0 the stop period is 16 cycles of 1. With `stop_sel`=1 it is 32 cycles, except for 5-bit characters, where it is 24 cycles.
- R8: The format fields are captured while `ctrl_stb` is high. A capture made during a frame does not change that frame; it applies to the next frame.
- R9: A character loaded while a frame is being sent starts on the edge that ends the last stop cycle, with no idle cycle in between, and `shift_empty` stays 0 across the boundary.
- R10: Whenever `shift_empty` is 1, `ser_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock at 16x the bit rate |
| rst_n | input | 1 | Synchronous active-low master reset |
| load_stb | input | 1 | Writes `hold_data` into the holding buffer |
| hold_data | input | 8 | Character to send, LSB sent first |
| ctrl_stb | input | 1 | Captures the format fields while high |
| len_sel | input | 2 | Character length select (00=5 to 11=8) |
| par_off | input | 1 | 1 suppresses the parity bit |
| par_even | input | 1 | 1 selects even parity, 0 odd |
| stop_sel | input | 1 | 0 gives one stop bit, 1 gives two (1.5 for 5-bit) |
| ser_out | output | 1 | Serial line, high when idle |
| hold_empty | output | 1 | Holding buffer can accept a character |
| shift_empty | output | 1 | No frame is being sent |

## Verification
The assertions assume that `rst_n` is low at the first clock edge and that the strobes and format fields change only between edges. They also assume that `load_stb` is raised only while `hold_empty` is 1, so that no character is overwritten before it is used. The stimulus drives every input on the falling edge. It writes a new character only when the buffer is empty: directly after a frame has finished, or on the first cycle of a frame, when the previous character has just left the buffer. Random formats and data are applied only while the shifter is idle. The only exception is the directed case that changes the format on purpose during a frame.

// File: rtl/tx_fmt_pkg.sv
// Package: shared format type and helpers for the serial transmitter.
// Assumes character lengths run from 5 up to the data width (8 by default).
package tx_fmt_pkg;

    // Latched frame format.
    typedef struct packed {
        logic [1:0] len_sel;   // 00=5 bits .. 11=8 bits
        logic       par_off;   // 1 = no parity bit
        logic       par_even;  // 1 = even, 0 = odd
        logic       stop_sel;  // 0 = one stop, 1 = two (1.5 when 5-bit)
    } tx_fmt_t;

    localparam tx_fmt_t FMT_RESET = '{len_sel: 2'b11, par_off: 1'b1,
                                      par_even: 1'b0, stop_sel: 1'b0};

    // Number of data bits for a given select, for a data width dw.
    function automatic int char_bits(input int dw, input logic [1:0] sel);
        return dw - 3 + int'(sel);
    endfunction

endpackage

// File: rtl/tx_fmt_latch.sv
// Module: format register. Captures the format fields while the strobe is high.
// Assumes the strobe and fields are stable around the clock edge.
module tx_fmt_latch
    import tx_fmt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    ctrl_stb,
    input  tx_fmt_t fmt_in,
    output tx_fmt_t fmt_q
);

    // Hold the last captured format; reset selects 8 bits, no parity, one stop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fmt_q <= FMT_RESET;
        else if (ctrl_stb)
            fmt_q <= fmt_in;
    end

endmodule

// File: rtl/tx_hold_buf.sv
// Module: holding buffer. Stores one character and a full flag.
// A transfer to the shifter empties it; a load in the same cycle refills it.
module tx_hold_buf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_stb,
    input  logic [DW-1:0] din,
    input  logic          xfer,
    output logic [DW-1:0] hold_q,
    output logic          hold_full
);

    // Capture the character on a load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (load_stb)
            hold_q <= din;
    end

    // Track occupancy: load sets, transfer clears, load wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_full <= 1'b0;
        else if (load_stb)
            hold_full <= 1'b1;
        else if (xfer)
            hold_full <= 1'b0;
    end

endmodule

// File: rtl/tx_frame_shift.sv
// Module: frame shifter. On start it builds the whole frame from the data and
// the format, then shifts one bit every TICKS cycles onto the line and counts
// down the total frame length, including a half-length final stop bit.
// Assumes TICKS is even and at least 2. start is only raised while ready is 1.
module tx_frame_shift
    import tx_fmt_pkg::*;
#(
    parameter int DW    = 8,
    parameter int TICKS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] data,
    input  tx_fmt_t       fmt,
    output logic          ser_out,
    output logic          busy,
    output logic          ready
);

    localparam int FRAME_W = DW + 4;                 // start + data + parity + 2 stop
    localparam int CYC_MAX = FRAME_W * TICKS;
    localparam int CNT_W   = $clog2(CYC_MAX + 1);
    localparam int PH_W    = $clog2(TICKS);
    localparam int HALF    = TICKS / 2;

    logic [FRAME_W-1:0] frame_new;
    logic [CNT_W-1:0]   total_new;
    logic [FRAME_W-1:0] sh_q;
    logic [CNT_W-1:0]   left_q;
    logic [PH_W-1:0]    phase_q;

    // Build the frame image and its length in cycles from data and format.
    always_comb begin
        int  n;
        int  cycles;
        logic par;
        n         = char_bits(DW, fmt.len_sel);
        par       = 1'b0;
        frame_new = '1;
        frame_new[0] = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (i < n) begin
                frame_new[i + 1] = data[i];
                par = par ^ data[i];
            end
        end
        for (int j = 0; j <= DW; j++) begin
            if (!fmt.par_off && j == n)
                frame_new[j + 1] = fmt.par_even ? par : ~par;
        end
        cycles = TICKS * (1 + n + (fmt.par_off ? 0 : 1));
        if (!fmt.stop_sel)
            cycles = cycles + TICKS;
        else if (fmt.len_sel == 2'b00)
            cycles = cycles + TICKS + HALF;
        else
            cycles = cycles + 2 * TICKS;
        total_new = CNT_W'(cycles - 1);
    end

    // Run the frame: load on start, shift every TICKS cycles, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '1;
            left_q  <= '0;
            phase_q <= '0;
            busy    <= 1'b0;
        end else if (start) begin
            sh_q    <= frame_new;
            left_q  <= total_new;
            phase_q <= '0;
            busy    <= 1'b1;
        end else if (busy) begin
            if (left_q == '0) begin
                busy <= 1'b0;
                sh_q <= '1;
            end else begin
                left_q <= left_q - 1'b1;
                if (phase_q == PH_W'(TICKS - 1)) begin
                    phase_q <= '0;
                    sh_q    <= {1'b1, sh_q[FRAME_W-1:1]};
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end
        end
    end

    assign ser_out = sh_q[0];
    assign ready   = !busy || (left_q == '0);

endmodule

// File: rtl/async_tx_top.sv
// Module: programmable-format asynchronous serial transmitter.
// Clocked at TICKS times the bit rate; double-buffers one character ahead of
// the shifter; the format is sampled when a character enters the shifter.
module async_tx_top
    import tx_fmt_pkg::*;
#(
    parameter int DW    = 8,
    parameter int TICKS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_stb,
    input  logic [DW-1:0] hold_data,
    input  logic          ctrl_stb,
    input  logic [1:0]    len_sel,
    input  logic          par_off,
    input  logic          par_even,
    input  logic          stop_sel,
    output logic          ser_out,
    output logic          hold_empty,
    output logic          shift_empty
);

    tx_fmt_t       fmt_in;
    tx_fmt_t       fmt_q;
    logic [DW-1:0] hold_q;
    logic          hold_full;
    logic          sh_busy;
    logic          sh_ready;
    logic          xfer;

    assign fmt_in = '{len_sel: len_sel, par_off: par_off,
                      par_even: par_even, stop_sel: stop_sel};

    tx_fmt_latch i_fmt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_stb (ctrl_stb),
        .fmt_in   (fmt_in),
        .fmt_q    (fmt_q)
    );

    tx_hold_buf #(.DW(DW)) i_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_stb  (load_stb),
        .din       (hold_data),
        .xfer      (xfer),
        .hold_q    (hold_q),
        .hold_full (hold_full)
    );

    // Move a waiting character whenever the shifter can accept it.
    assign xfer = hold_full && sh_ready;

    tx_frame_shift #(.DW(DW), .TICKS(TICKS)) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (xfer),
        .data    (hold_q),
        .fmt     (fmt_q),
        .ser_out (ser_out),
        .busy    (sh_busy),
        .ready   (sh_ready)
    );

    assign hold_empty  = !hold_full;
    assign shift_empty = !sh_busy;

endmodule

// File: rtl/async_tx_sva.sv
// Checker: port-level properties of the serial transmitter, bound to the top.
// Assumes reset is low at the first edge and loads only while the buffer is empty.
module async_tx_sva (
    input logic clk,
    input logic rst_n,
    input logic load_stb,
    input logic ser_out,
    input logic hold_empty,
    input logic shift_empty
);

    logic rst_was_low = 1'b0;

    // R1: one edge after a low reset, the outputs show the reset state.
    always @(posedge clk) begin
        if (rst_was_low)
            a_r1_reset_state: assert (ser_out && hold_empty && shift_empty)
                else $error("reset state not reached");
        rst_was_low <= !rst_n;
    end

    // R2: a load makes the buffer non-empty.
    a_r2_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !hold_empty);

    // R2: the buffer empties only by handing its character to the shifter.
    a_r2_xfer_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_empty) |-> !shift_empty);

    // R3: a frame leaving idle begins with a low start bit.
    a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty) |-> !ser_out);

    // R10: the line is at mark whenever no frame is in progress.
    a_r10_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> ser_out);

endmodule

bind async_tx_top async_tx_sva i_async_tx_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_stb    (load_stb),
    .ser_out     (ser_out),
    .hold_empty  (hold_empty),
    .shift_empty (shift_empty)
);

// File: tb/test_async_tx_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random frames, each compared
// cycle by cycle against a frame image computed here from the requirements.
module test_async_tx_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_stb = 1'b0;
    logic [7:0] hold_data = 8'h00;
    logic       ctrl_stb = 1'b0;
    logic [1:0] len_sel = 2'b11;
    logic       par_off = 1'b1;
    logic       par_even = 1'b0;
    logic       stop_sel = 1'b0;
    logic       ser_out;
    logic       hold_empty;
    logic       shift_empty;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    async_tx_top i_async_tx_top (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .hold_data(hold_data),
        .ctrl_stb(ctrl_stb), .len_sel(len_sel), .par_off(par_off),
        .par_even(par_even), .stop_sel(stop_sel), .ser_out(ser_out),
        .hold_empty(hold_empty), .shift_empty(shift_empty)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Frame image: bit 0 start, data LSB first, optional parity, then ones.
    function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic [1:0] len,
                                              input bit poff, input bit peven);
        logic [11:0] f;
        bit p;
        int n;
        n = 5 + int'(len);
        f = '1;
        f[0] = 1'b0;
        p = 1'b0;
        for (int i = 0; i < n; i++) begin
            f[i + 1] = d[i];
            p = p ^ d[i];
        end
        if (!poff) f[n + 1] = peven ? p : !p;
        return f;
    endfunction

    function automatic int exp_cycles(input logic [1:0] len, input bit poff, input bit stop);
        int c;
        c = 16 * (1 + 5 + int'(len) + (poff ? 0 : 1));
        if (!stop) c = c + 16;
        else if (len == 2'b00) c = c + 24;
        else c = c + 32;
        return c;
    endfunction

    task automatic set_fmt(input logic [1:0] len, input bit poff, input bit peven, input bit stop);
        len_sel = len; par_off = poff; par_even = peven; stop_sel = stop;
        ctrl_stb = 1'b1;
        @(negedge clk);
        ctrl_stb = 1'b0;
    endtask

    // Samples the current negedge as cycle 0 of a frame; releases strobes at cycle 1.
    task automatic run_frame(input logic [11:0] f, input int cyc, input string tag);
        int bad;
        bad = 0;
        for (int i = 0; i < cyc; i++) begin
            if (i > 0) @(negedge clk);
            if (i == 1) begin load_stb = 1'b0; ctrl_stb = 1'b0; end
            if (ser_out !== ((i / 16) < 12 ? f[i / 16] : 1'b1)) bad++;
            if (shift_empty !== 1'b0) bad++;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    // Single frame from idle, with flag checks around it.
    task automatic play(input logic [7:0] d, input logic [1:0] len, input bit poff,
                        input bit peven, input bit stop, input string tag);
        hold_data = d;
        load_stb = 1'b1;
        @(negedge clk);
        load_stb = 1'b0;
        check(hold_empty == 1'b0 && shift_empty == 1'b1, "R2 load fills buffer",
              {hold_empty, shift_empty}, 1);
        @(negedge clk);
        check(hold_empty == 1'b1 && shift_empty == 1'b0, "R2 transfer to shifter",
              {hold_empty, shift_empty}, 2);
        run_frame(exp_frame(d, len, poff, peven), exp_cycles(len, poff, stop), tag);
        @(negedge clk);
        check(shift_empty == 1'b1 && ser_out == 1'b1, "R10 idle after frame",
              {shift_empty, ser_out}, 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [1:0] l;
        bit po, pe, st;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(ser_out && hold_empty && shift_empty, "R1 reset state",
              {ser_out, hold_empty, shift_empty}, 7);
        @(negedge clk);

        // R3/R4: each length, no parity, one stop
        for (int k = 0; k < 4; k++) begin
            set_fmt(2'(k), 1'b1, 1'b0, 1'b0);
            play(8'hA6 ^ 8'(k), 2'(k), 1'b1, 1'b0, 1'b0, "R4 length select");
        end
        // R4: upper holding bits ignored in 5-bit mode
        set_fmt(2'b00, 1'b1, 1'b0, 1'b0);
        play(8'hE0, 2'b00, 1'b1, 1'b0, 1'b0, "R4 upper bits ignored");
        // R5: parity off, both senses give the same line
        set_fmt(2'b11, 1'b1, 1'b1, 1'b0);
        play(8'h5B, 2'b11, 1'b1, 1'b1, 1'b0, "R5 parity off even");
        set_fmt(2'b11, 1'b1, 1'b0, 1'b0);
        play(8'h5B, 2'b11, 1'b1, 1'b0, 1'b0, "R5 parity off odd");
        // R6: parity senses
        set_fmt(2'b10, 1'b0, 1'b1, 1'b0);
        play(8'h13, 2'b10, 1'b0, 1'b1, 1'b0, "R6 even parity");
        set_fmt(2'b10, 1'b0, 1'b0, 1'b0);
        play(8'h13, 2'b10, 1'b0, 1'b0, 1'b0, "R6 odd parity");
        // R7: two stop bits and one and a half
        set_fmt(2'b01, 1'b0, 1'b1, 1'b1);
        play(8'h2D, 2'b01, 1'b0, 1'b1, 1'b1, "R7 two stop");
        set_fmt(2'b00, 1'b0, 1'b0, 1'b1);
        play(8'h1F, 2'b00, 1'b0, 1'b0, 1'b1, "R7 one and a half stop");

        // R8/R9: back-to-back frames with a format change during the first
        set_fmt(2'b11, 1'b0, 1'b1, 1'b0);
        hold_data = 8'hC3; load_stb = 1'b1;
        @(negedge clk);
        load_stb = 1'b0;
        @(negedge clk);
        hold_data = 8'h35; load_stb = 1'b1;
        len_sel = 2'b00; par_off = 1'b1; par_even = 1'b0; stop_sel = 1'b1; ctrl_stb = 1'b1;
        run_frame(exp_frame(8'hC3, 2'b11, 1'b0, 1'b1), exp_cycles(2'b11, 1'b0, 1'b0),
                  "R8 frame keeps old format");
        @(negedge clk);
        check(shift_empty == 1'b0 && hold_empty == 1'b1, "R9 no idle gap",
              {shift_empty, hold_empty}, 1);
        run_frame(exp_frame(8'h35, 2'b00, 1'b1, 1'b0), exp_cycles(2'b00, 1'b1, 1'b1),
                  "R9 second frame with new format R8");
        @(negedge clk);
        check(shift_empty == 1'b1 && ser_out == 1'b1, "R10 idle after pair",
              {shift_empty, ser_out}, 3);

        // R1: reset in mid-frame
        set_fmt(2'b11, 1'b0, 1'b0, 1'b1);
        hold_data = 8'h00; load_stb = 1'b1;
        @(negedge clk);
        load_stb = 1'b0;
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(ser_out && hold_empty && shift_empty, "R1 reset mid-frame",
              {ser_out, hold_empty, shift_empty}, 7);
        repeat (20) @(negedge clk);
        check(ser_out && shift_empty, "R1 stays idle after reset",
              {ser_out, shift_empty}, 3);

        // R3: seeded random formats and data
        for (int k = 0; k < 40; k++) begin
            d = 8'($urandom);
            l = 2'($urandom % 4);
            po = 1'($urandom % 2);
            pe = 1'($urandom % 2);
            st = 1'($urandom % 2);
            set_fmt(l, po, pe, st);
            play(d, l, po, pe, st, "R3 random frame");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule